// File: doc/BRIEF.md
# Configuration Mechanism Probe Sequencer

This block decides which configuration-access method a host bridge implements. On a start pulse it runs an ordered series of I/O accesses through a simple master port and classifies the bridge. The result code is 1 for the address/data-port method, 2 for the enable/forward-register method, and 0 when neither is found. A done flag accompanies the result. The sequence begins by saving the 32-bit address port at 0xCF8. It then tries a small programmable list of known bridges whose address-port behaviour is non-standard but which answer a configuration read correctly. Next comes a strict test of the address/data-port method. The weaker enable/forward-register test runs last.

The known-bridge list is loaded through a write port, one entry at a time. Each entry holds a configuration tag, meaning the full 32-bit address-port value, and the ID dword that a real device at that tag would return. A forced-mode input lets the integrator skip all I/O and report a fixed answer. Once a result exists it is cached. A later start returns the same answer without touching the bus, unless the start comes with the clear input.

Top module: `cfgmech_probe`

## Requirements
- R1: A probe begins on a start pulse while idle when no result is cached or clear is high. Its first access is a dword read of 0xCF8, and the value read is kept as the saved address.
- R2: Entries in the known-bridge list are visited from index 0 upward, and a zero tag ends the list. For each entry the block writes the tag as a dword to 0xCF8, reads a dword from 0xCFC, then writes dword 0 to 0xCF8. If the value read equals the entry's ID, the block finishes with result 1 and makes no further access.
- R3: The strict test writes dword 0x80000000 to 0xCF8, then byte 0 to 0xCFB, then word 0 to 0xCFA, then reads a dword from 0xCF8. The test continues only if (value & 0x80FFFFFC) == 0x80000000.
- R4: After that first check passes, the block writes dword 0 to 0xCF8 and reads 0xCF8 back. If the masked value is zero the result is 1.
- R5: If either strict check fails, the saved address is written back to 0xCF8 as a dword before any further access.
- R6: The weak test writes byte 0 to 0xCF8 and byte 0 to 0xCFA, then reads a byte from 0xCF8 and a byte from 0xCFA. The result is 2 if both bytes are zero and 0 otherwise.
- R7: A start with force_en high makes no I/O access. Done is high in the next cycle, and the result is force_mode when force_mode is 1 or 2, else 0.
- R8: A start while a result is cached and clear is low makes no I/O access and leaves the result and done unchanged. This holds even when force_en is high. A start with clear high probes again.
- R9: A request holds io_addr, io_size, io_wr and io_wdata steady until io_ack. Size codes are 0 for byte, 1 for word and 2 for dword. Byte and word data sit right-justified in the low bits of io_wdata and io_rdata, and dword accesses are 4-byte aligned.
- R10: During a probe, busy is high and done is low. While idle no request is made, and the result and done hold until the next start.
- R11: tbl_we writes tbl_tag and tbl_id into entry tbl_idx. Reset clears every tag to zero, so a probe after reset skips the list entirely.
- R12: When every list entry holds a nonzero tag and none matches, the scan stops after the last entry and the strict test follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| clear | input | 1 | With start, discard any cached result and probe again |
| force_en | input | 1 | With start, report force_mode without I/O |
| force_mode | input | 2 | Forced result code |
| tbl_we | input | 1 | Known-bridge list write strobe |
| tbl_idx | input | IW | List entry index |
| tbl_tag | input | 32 | Entry tag (address-port value) |
| tbl_id | input | 32 | Entry expected ID dword |
| io_req | output | 1 | I/O request |
| io_wr | output | 1 | 1 = write, 0 = read |
| io_addr | output | AW | I/O byte address |
| io_size | output | 2 | 0 byte, 1 word, 2 dword |
| io_wdata | output | 32 | Write data, right-justified |
| io_ack | input | 1 | Access complete; read data valid |
| io_rdata | input | 32 | Read data, right-justified |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Result valid |
| result | output | 2 | 0 none, 1 address/data method, 2 enable/forward method |

## Verification
The hardest path to reach from the ports passes the first strict check, fails the second, and must then restore the exact value saved at the start. The bench's bridge model includes a variant whose enable bit reads back stuck at one, which drives the sequence down that path. A second variant is a plain byte-lane register. It fails the strict test, yet it can answer a configuration read, so the known-bridge list decides the result before the weak test would report a false positive. Every bridge variant is swept against six list layouts and two saved-address values, and each whole access trace is compared with a sequence the bench builds from the requirements.

// File: rtl/cfgmech_pkg.sv
package cfgmech_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_SAVE, ST_QSEL, ST_QADR, ST_QDAT, ST_QCLR,
    ST_M1EN, ST_M1B3, ST_M1W2, ST_M1RD1, ST_M1ZR, ST_M1RD2,
    ST_REST, ST_M2EN, ST_M2FW, ST_M2RE, ST_M2RF
  } step_e;

  typedef logic [1:0] mech_t;
  localparam mech_t MECH_NONE = 2'd0;
  localparam mech_t MECH_ONE  = 2'd1;
  localparam mech_t MECH_TWO  = 2'd2;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  localparam logic [1:0] WS_ZERO   = 2'd0;
  localparam logic [1:0] WS_ENABLE = 2'd1;
  localparam logic [1:0] WS_TAG    = 2'd2;
  localparam logic [1:0] WS_SAVED  = 2'd3;

  localparam logic [31:0] M1_ENABLE = 32'h8000_0000;
  localparam logic [31:0] M1_MASK   = 32'h80FF_FFFC;

  // One I/O access as seen by the step decoder
  typedef struct packed {
    logic       req;
    logic       wr;
    logic [1:0] size;
    logic       dport;  // 1 = data port, 0 = address port
    logic [1:0] lane;   // byte offset from the selected port
    logic [1:0] wsel;   // write data source
  } io_step_t;

  function automatic logic m1_enable_ok(logic [31:0] v);
    return (v & M1_MASK) == M1_ENABLE;
  endfunction

  function automatic logic m1_clear_ok(logic [31:0] v);
    return (v & M1_MASK) == 32'h0;
  endfunction

  function automatic mech_t m2_verdict(logic [7:0] en_b, logic [7:0] fw_b);
    return (en_b == 8'h00 && fw_b == 8'h00) ? MECH_TWO : MECH_NONE;
  endfunction

  function automatic mech_t force_map(logic [1:0] m);
    return (m == MECH_ONE || m == MECH_TWO) ? m : MECH_NONE;
  endfunction

  function automatic io_step_t step_of(step_e s);
    io_step_t t;
    t = '0;
    t.req = 1'b1;
    case (s)
      ST_SAVE:  begin t.size = SZ_DWORD; end
      ST_QADR:  begin t.wr = 1'b1; t.size = SZ_DWORD; t.wsel = WS_TAG; end
      ST_QDAT:  begin t.size = SZ_DWORD; t.dport = 1'b1; end
      ST_QCLR:  begin t.wr = 1'b1; t.size = SZ_DWORD; t.wsel = WS_ZERO; end
      ST_M1EN:  begin t.wr = 1'b1; t.size = SZ_DWORD; t.wsel = WS_ENABLE; end
      ST_M1B3:  begin t.wr = 1'b1; t.size = SZ_BYTE; t.lane = 2'd3; end
      ST_M1W2:  begin t.wr = 1'b1; t.size = SZ_WORD; t.lane = 2'd2; end
      ST_M1RD1: begin t.size = SZ_DWORD; end
      ST_M1ZR:  begin t.wr = 1'b1; t.size = SZ_DWORD; end
      ST_M1RD2: begin t.size = SZ_DWORD; end
      ST_REST:  begin t.wr = 1'b1; t.size = SZ_DWORD; t.wsel = WS_SAVED; end
      ST_M2EN:  begin t.wr = 1'b1; t.size = SZ_BYTE; end
      ST_M2FW:  begin t.wr = 1'b1; t.size = SZ_BYTE; t.lane = 2'd2; end
      ST_M2RE:  begin t.size = SZ_BYTE; end
      ST_M2RF:  begin t.size = SZ_BYTE; t.lane = 2'd2; end
      default:  begin t.req = 1'b0; end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/cfgmech_qtable.sv
module cfgmech_qtable #(
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter int TW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [TW-1:0] wtag,
  input  logic [TW-1:0] wid,
  input  logic [IW-1:0] ridx,
  output logic [TW-1:0] rtag,
  output logic [TW-1:0] rid
);

  logic [TW-1:0] tag_q [DEPTH];
  logic [TW-1:0] id_q  [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tag_q[g] <= '0;
          id_q[g]  <= '0;
        end else if (we && widx == IW'(g)) begin
          tag_q[g] <= wtag;
          id_q[g]  <= wid;
        end
      end
    end
  endgenerate

  always_comb begin
    rtag = '0;
    rid  = '0;
    if (32'(ridx) < DEPTH) begin
      rtag = tag_q[ridx];
      rid  = id_q[ridx];
    end
  end

endmodule

// File: rtl/cfgmech_stepdec.sv
module cfgmech_stepdec
  import cfgmech_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input  step_e        step,
  input  logic [31:0]  q_tag,
  input  logic [31:0]  saved,
  output logic         io_req,
  output logic         io_wr,
  output logic [AW-1:0] io_addr,
  output logic [1:0]   io_size,
  output logic [31:0]  io_wdata
);

  io_step_t cur;

  always_comb begin
    cur      = step_of(step);
    io_req   = cur.req;
    io_wr    = cur.wr;
    io_size  = cur.size;
    io_addr  = (cur.dport ? AW'(DATA_PORT) : AW'(ADDR_PORT)) + AW'(cur.lane);
    case (cur.wsel)
      WS_ENABLE: io_wdata = M1_ENABLE;
      WS_TAG:    io_wdata = q_tag;
      WS_SAVED:  io_wdata = saved;
      default:   io_wdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/cfgmech_seq.sv
module cfgmech_seq
  import cfgmech_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clear,
  input  logic          force_en,
  input  logic [1:0]    force_mode,
  input  logic          io_req,
  input  logic          io_ack,
  input  logic [31:0]   io_rdata,
  input  logic [31:0]   q_tag,
  input  logic [31:0]   q_id,
  output step_e         step,
  output logic [IW-1:0] q_idx,
  output logic [31:0]   saved,
  output logic          busy,
  output logic          done,
  output mech_t         result,
  output logic          ev_quirk_hit,
  output logic          ev_m1_pass
);

  step_e         st;
  logic [CW-1:0] cnt;
  logic          hit_q;
  logic [7:0]    en_byte_q;
  logic [31:0]   saved_q;
  logic          done_q;
  mech_t         res_q;

  logic fire;
  logic cnt_ok;
  logic accept;

  assign fire   = io_req & io_ack;
  assign cnt_ok = 32'(cnt) < DEPTH;
  assign accept = start && !(done_q && !clear);

  assign ev_quirk_hit = (st == ST_QCLR) && fire && hit_q;
  assign ev_m1_pass   = (st == ST_M1RD2) && fire && m1_clear_ok(io_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      hit_q     <= 1'b0;
      en_byte_q <= 8'h0;
      saved_q   <= 32'h0;
      done_q    <= 1'b0;
      res_q     <= MECH_NONE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (force_en) begin
              res_q  <= force_map(force_mode);
              done_q <= 1'b1;
            end else begin
              done_q <= 1'b0;
              cnt    <= '0;
              hit_q  <= 1'b0;
              st     <= ST_SAVE;
            end
          end
        end
        ST_SAVE: if (fire) begin
          saved_q <= io_rdata;
          st      <= ST_QSEL;
        end
        ST_QSEL: st <= (cnt_ok && q_tag != 32'h0) ? ST_QADR : ST_M1EN;
        ST_QADR: if (fire) st <= ST_QDAT;
        ST_QDAT: if (fire) begin
          hit_q <= (io_rdata == q_id);
          st    <= ST_QCLR;
        end
        ST_QCLR: if (fire) begin
          if (hit_q) begin
            res_q  <= MECH_ONE;
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= ST_QSEL;
          end
        end
        ST_M1EN:  if (fire) st <= ST_M1B3;
        ST_M1B3:  if (fire) st <= ST_M1W2;
        ST_M1W2:  if (fire) st <= ST_M1RD1;
        ST_M1RD1: if (fire) st <= m1_enable_ok(io_rdata) ? ST_M1ZR : ST_REST;
        ST_M1ZR:  if (fire) st <= ST_M1RD2;
        ST_M1RD2: if (fire) begin
          if (m1_clear_ok(io_rdata)) begin
            res_q  <= MECH_ONE;
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            st <= ST_REST;
          end
        end
        ST_REST: if (fire) st <= ST_M2EN;
        ST_M2EN: if (fire) st <= ST_M2FW;
        ST_M2FW: if (fire) st <= ST_M2RE;
        ST_M2RE: if (fire) begin
          en_byte_q <= io_rdata[7:0];
          st        <= ST_M2RF;
        end
        ST_M2RF: if (fire) begin
          res_q  <= m2_verdict(en_byte_q, io_rdata[7:0]);
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign step   = st;
  assign q_idx  = cnt[IW-1:0];
  assign saved  = saved_q;
  assign busy   = (st != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;

endmodule

// File: rtl/cfgmech_probe.sv
module cfgmech_probe
  import cfgmech_pkg::*;
#(
  parameter int          DEPTH     = 4,
  parameter int          AW        = 16,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC,
  localparam int         IW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int         CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clear,
  input  logic          force_en,
  input  logic [1:0]    force_mode,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_idx,
  input  logic [31:0]   tbl_tag,
  input  logic [31:0]   tbl_id,
  output logic          io_req,
  output logic          io_wr,
  output logic [AW-1:0] io_addr,
  output logic [1:0]    io_size,
  output logic [31:0]   io_wdata,
  input  logic          io_ack,
  input  logic [31:0]   io_rdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result
);

  step_e         step_w;
  logic [IW-1:0] q_idx_w;
  logic [31:0]   q_tag_w;
  logic [31:0]   q_id_w;
  logic [31:0]   saved_w;
  logic          ev_quirk_hit;
  logic          ev_m1_pass;

  cfgmech_qtable #(.DEPTH(DEPTH), .IW(IW), .TW(32)) u_tbl (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (tbl_we),
    .widx (tbl_idx),
    .wtag (tbl_tag),
    .wid  (tbl_id),
    .ridx (q_idx_w),
    .rtag (q_tag_w),
    .rid  (q_id_w)
  );

  cfgmech_seq #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .clear       (clear),
    .force_en    (force_en),
    .force_mode  (force_mode),
    .io_req      (io_req),
    .io_ack      (io_ack),
    .io_rdata    (io_rdata),
    .q_tag       (q_tag_w),
    .q_id        (q_id_w),
    .step        (step_w),
    .q_idx       (q_idx_w),
    .saved       (saved_w),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .ev_quirk_hit(ev_quirk_hit),
    .ev_m1_pass  (ev_m1_pass)
  );

  cfgmech_stepdec #(.AW(AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_dec (
    .step    (step_w),
    .q_tag   (q_tag_w),
    .saved   (saved_w),
    .io_req  (io_req),
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .io_size (io_size),
    .io_wdata(io_wdata)
  );

endmodule

// File: rtl/cfgmech_probe_chk.sv
module cfgmech_probe_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          clear,
  input logic          force_en,
  input logic [1:0]    force_mode,
  input logic          io_req,
  input logic          io_wr,
  input logic [AW-1:0] io_addr,
  input logic [1:0]    io_size,
  input logic [31:0]   io_wdata,
  input logic          io_ack,
  input logic          busy,
  input logic          done,
  input logic [1:0]    result,
  input logic          ev_quirk_hit,
  input logic          ev_m1_pass
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !io_ack |=> io_req && $stable(io_addr) && $stable(io_size)
                          && $stable(io_wr) && $stable(io_wdata));

  // R9
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> (io_size != 2'd3) && (io_size != 2'd2 || io_addr[1:0] == 2'd0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !io_req);

  // R10
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(result));

  // R7
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && force_en && (!done || clear) |=>
      done && !busy && !io_req &&
      (result == (($past(force_mode) == 2'd3) ? 2'd0 : $past(force_mode))));

  // R8
  cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && done && start && !clear |=> !busy && done && !io_req && $stable(result));

  // R2
  quirk_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_quirk_hit |=> done && !busy && result == 2'd1);

  // R4
  m1_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_m1_pass |=> done && !busy && result == 2'd1);

endmodule

bind cfgmech_probe cfgmech_probe_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .clear       (clear),
  .force_en    (force_en),
  .force_mode  (force_mode),
  .io_req      (io_req),
  .io_wr       (io_wr),
  .io_addr     (io_addr),
  .io_size     (io_size),
  .io_wdata    (io_wdata),
  .io_ack      (io_ack),
  .busy        (busy),
  .done        (done),
  .result      (result),
  .ev_quirk_hit(ev_quirk_hit),
  .ev_m1_pass  (ev_m1_pass)
);

// File: tb/sim_cfgmech_probe.sv
`timescale 1ns/1ps
module sim_cfgmech_probe;

  localparam int          DEPTH = 4;
  localparam logic [15:0] AP    = 16'h0CF8;
  localparam logic [15:0] DP    = 16'h0CFC;
  localparam logic [31:0] MTAG  = 32'h8000_1800;
  localparam logic [31:0] MID   = 32'h5A17_C0DE;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, clear = 1'b0, force_en = 1'b0;
  logic [1:0]  force_mode = 2'd0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_idx = 2'd0;
  logic [31:0] tbl_tag = 32'h0, tbl_id = 32'h0;
  logic        io_req, io_wr;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic [31:0] io_wdata;
  logic        io_ack = 1'b0;
  logic [31:0] io_rdata = 32'h0;
  logic        busy, done;
  logic [1:0]  result;

  always #2.5 clk = ~clk;

  cfgmech_probe u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
    .force_en(force_en), .force_mode(force_mode),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_tag(tbl_tag), .tbl_id(tbl_id),
    .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr), .io_size(io_size),
    .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
    .busy(busy), .done(done), .result(result)
  );

  // Bridge model: kind 0 nothing, 1 strict address/data ports,
  // 2 plain byte-lane register, 3 strict with enable bit stuck at one
  int          kind = 0;
  logic [31:0] mreg = 32'h0, init_val = 32'h0;
  logic        mload = 1'b0;
  logic [15:0] tr_addr [4096];
  logic [1:0]  tr_size [4096];
  logic        tr_wr   [4096];
  logic [31:0] tr_wd   [4096];
  int          tr_n = 0;

  function automatic logic [31:0] szmask(logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] model_read(logic [15:0] a, logic [1:0] s,
                                             logic [31:0] r, int k);
    logic [31:0] v;
    if (k == 0) v = 32'hFFFF_FFFF;
    else if (a == DP) v = ((r | 32'h8000_0000) == MTAG) ? MID : 32'hFFFF_FFFF;
    else begin
      v = (k == 3) ? (r | 32'h8000_0000) : r;
      v = v >> (8 * a[1:0]);
    end
    return v & szmask(s);
  endfunction

  always @(posedge clk) begin
    if (mload) mreg <= init_val;
    io_ack <= 1'b0;
    if (io_req && !io_ack) begin
      io_ack <= 1'b1;
      tr_addr[tr_n % 4096] <= io_addr;
      tr_size[tr_n % 4096] <= io_size;
      tr_wr[tr_n % 4096]   <= io_wr;
      tr_wd[tr_n % 4096]   <= io_wdata;
      tr_n <= tr_n + 1;
      if (!io_wr) io_rdata <= model_read(io_addr, io_size, mreg, kind);
      else if (io_addr[15:2] == AP[15:2]) begin
        if (kind == 1 || kind == 3) begin
          if (io_size == 2'd2) mreg <= io_wdata;
        end else if (kind == 2) begin
          case (io_size)
            2'd0:    mreg[8*io_addr[1:0] +: 8]  <= io_wdata[7:0];
            2'd1:    mreg[8*io_addr[1:0] +: 16] <= io_wdata[15:0];
            default: mreg <= io_wdata;
          endcase
        end
      end
    end
  end

  int  checks = 0, fails = 0;
  bit  finished = 1'b0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench copy of the list
  logic [31:0] tb_tag [DEPTH];
  logic [31:0] tb_id  [DEPTH];

  task automatic set_entry(int i, logic [31:0] t, logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 2'(i); tbl_tag = t; tbl_id = d;
    tb_tag[i] = t; tb_id[i] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin tb_tag[i] = 32'h0; tb_id[i] = 32'h0; end
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // expected trace
  logic [15:0] ex_addr [64];
  logic [1:0]  ex_size [64];
  logic        ex_wr   [64];
  logic [31:0] ex_wd   [64];
  int          ex_n;

  task automatic push(logic [15:0] a, logic [1:0] s, logic w, logic [31:0] d);
    ex_addr[ex_n] = a; ex_size[ex_n] = s; ex_wr[ex_n] = w; ex_wd[ex_n] = d;
    ex_n++;
  endtask

  int base;
  bit first_busy, first_done;

  task automatic run(int k, logic [31:0] init, bit fen, logic [1:0] fm, bit clr);
    int n;
    @(negedge clk);
    kind = k; init_val = init; mload = 1'b1;
    @(negedge clk);
    mload = 1'b0;
    base = tr_n;
    force_en = fen; force_mode = fm; clear = clr; start = 1'b1;
    @(negedge clk);
    start = 1'b0; clear = 1'b0; force_en = 1'b0;
    first_busy = busy; first_done = done;
    n = 0;
    while ((busy || !done) && n < 2000) begin @(negedge clk); n++; end
  endtask

  // full probe with clear, checked against the bench's own expectation
  task automatic probe_check(int k, logic [31:0] init, string ctx);
    int sc; bit h; logic [1:0] er; logic [31:0] sv; int bad;
    sc = 0; h = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (tb_tag[i] == 32'h0) break;
      sc++;
      if (k != 0 && tb_tag[i] == MTAG && tb_id[i] == MID) begin h = 1'b1; break; end
    end
    sv = (k == 0) ? 32'hFFFF_FFFF : (k == 3) ? (init | 32'h8000_0000) : init;
    ex_n = 0;
    push(AP, 2'd2, 1'b0, 32'h0);
    for (int i = 0; i < sc; i++) begin
      push(AP, 2'd2, 1'b1, tb_tag[i]);
      push(DP, 2'd2, 1'b0, 32'h0);
      push(AP, 2'd2, 1'b1, 32'h0);
    end
    if (h) er = 2'd1;
    else begin
      push(AP, 2'd2, 1'b1, 32'h8000_0000);
      push(AP + 16'd3, 2'd0, 1'b1, 32'h0);
      push(AP + 16'd2, 2'd1, 1'b1, 32'h0);
      push(AP, 2'd2, 1'b0, 32'h0);
      if (k == 1 || k == 3) begin
        push(AP, 2'd2, 1'b1, 32'h0);
        push(AP, 2'd2, 1'b0, 32'h0);
      end
      if (k == 1) er = 2'd1;
      else begin
        push(AP, 2'd2, 1'b1, sv);
        push(AP, 2'd0, 1'b1, 32'h0);
        push(AP + 16'd2, 2'd0, 1'b1, 32'h0);
        push(AP, 2'd0, 1'b0, 32'h0);
        push(AP + 16'd2, 2'd0, 1'b0, 32'h0);
        if (k == 2) er = 2'd2;
        else if (k == 3) er = (init[7:0] == 8'h0 && init[23:16] == 8'h0) ? 2'd2 : 2'd0;
        else er = 2'd0;
      end
    end
    run(k, init, 1'b0, 2'd0, 1'b1);
    check(first_busy && !first_done, "R10", {ctx, " busy/done during probe"},
          {30'h0, first_busy, first_done}, 32'h2);
    check(done && result == er, h ? "R2" : (k == 1 ? "R4" : "R6"), {ctx, " result"},
          {29'h0, done, result}, {29'h0, 1'b1, er});
    check(tr_n - base == ex_n, "R3 R5 R12", {ctx, " access count"},
          32'(tr_n - base), 32'(ex_n));
    bad = -1;
    for (int i = 0; i < ex_n && i < tr_n - base; i++) begin
      int j;
      j = (base + i) % 4096;
      if (bad < 0 && (tr_addr[j] != ex_addr[i] || tr_size[j] != ex_size[i] ||
                      tr_wr[j] != ex_wr[i] || (ex_wr[i] && tr_wd[j] != ex_wd[i])))
        bad = i;
    end
    check(bad < 0, "R1 R3 R5 R9", {ctx, " access trace first mismatch index"},
          32'(bad), 32'hFFFF_FFFF);
  endtask

  task automatic load_cfg(int c);
    for (int i = 0; i < DEPTH; i++) set_entry(i, 32'h0, 32'h0);
    case (c)
      1: set_entry(0, 32'h8000_0800, 32'h1111_2222);
      2: set_entry(0, MTAG, MID);
      3: begin
        set_entry(0, 32'h8000_0800, MID);
        set_entry(1, MTAG, MID ^ 32'h1);
        set_entry(2, MTAG, MID);
      end
      4: begin
        set_entry(0, 32'h8000_0800, MID);
        set_entry(1, 32'h8000_1000, MID);
        set_entry(2, 32'h8001_1800, MID);
        set_entry(3, MTAG, 32'h0BAD_0BAD);
      end
      5: begin
        set_entry(0, 32'h8000_0800, MID);
        set_entry(2, MTAG, MID);
      end
      default: ;
    endcase
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin tb_tag[i] = 32'h0; tb_id[i] = 32'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!done && !busy && result == 2'd0 && !io_req, "R10", "reset state",
          {28'h0, done, busy, result}, 32'h0);

    // sweep: bridge kinds x list layouts x saved values
    for (int c = 0; c < 6; c++) begin
      load_cfg(c);
      for (int k = 0; k < 4; k++) begin
        probe_check(k, 32'h0000_0A04, $sformatf("cfg%0d kind%0d initA", c, k));
        probe_check(k, 32'h0000_0000, $sformatf("cfg%0d kind%0d initZ", c, k));
      end
    end

    // R7 forced modes, no I/O
    for (int m = 0; m < 4; m++) begin
      run(1, 32'h0, 1'b1, 2'(m), 1'b1);
      check(first_done && !first_busy, "R7", "forced done next cycle",
            {30'h0, first_done, first_busy}, 32'h2);
      check(result == ((m == 3) ? 2'd0 : 2'(m)), "R7", "forced result",
            32'(result), (m == 3) ? 32'h0 : 32'(m));
      check(tr_n == base, "R7", "forced access count", 32'(tr_n - base), 32'h0);
    end

    // R8 cached result
    load_cfg(0);
    probe_check(2, 32'h0, "R8 setup");
    run(1, 32'h0, 1'b0, 2'd0, 1'b0);
    check(done && result == 2'd2 && tr_n == base, "R8", "cached start, no I/O",
          {29'h0, done, result}, 32'h6);
    run(1, 32'h0, 1'b1, 2'd1, 1'b0);
    check(done && result == 2'd2 && tr_n == base, "R8", "cached start ignores force",
          {29'h0, done, result}, 32'h6);
    probe_check(1, 32'h0, "R8 clear reprobe");

    // R11 reset clears the list
    load_cfg(2);
    do_reset();
    check(!done && !busy && result == 2'd0, "R11", "state after second reset",
          {29'h0, done, result}, 32'h0);
    probe_check(2, 32'h0000_0A04, "R11 list empty after reset");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule